// File: doc/BRIEF.md
# Indirect Register Front End with Keyed Soft Reset

This block is the host-facing register front end of a serial bus controller. A host on an 8-bit parallel port sees a small direct map: a read-only status view, a data register, a control register, an index pointer and a window. Configuration that does not fit in the direct map sits in a bank of indirect registers. To reach one, the host writes its index into the pointer and then reads or writes the window. The bank holds the controller's own bus address, a timeout count, a mode value, and the low and high phase counts for the serial clock. The front end drives all of these to the serial engine as configuration outputs.

One index of the bank is a reset slot. An ordered two-byte key written to that slot, first 0xA5 and then 0x5A, fires a one-cycle soft reset. The front end exports this reset as a pulse, and on the next clock edge it returns every register to its default. Software must then reprogram the mode and the clock phase counts before the bus can run again. The own-address register keeps whatever value the host writes to it while other indirect registers change. Software reads it back to find out whether the indirect bank is present.

Top module: `ixreg_frontend`

## Requirements
- R1: After the synchronous reset, the data, pointer and control registers read 0x00. The indirect registers hold their defaults: own address 0xE0, clock low count 0x9D, clock high count 0x86, timeout 0xFF, mode 0x00.
- R2: The direct addresses are 0 status, 1 data, 2 pointer, 3 window and 4 control. Data, pointer and control read back the last value written to them. A write to status has no effect. Addresses 5 to 7 read 0x00.
- R3: The window reads and writes the indirect register selected by the pointer. The indices are 0 own address, 1 clock low count, 2 clock high count, 3 timeout, 4 mode and 5 reset slot. Each implemented register drives its cfg output.
- R4: A value written to the own-address register still reads back unchanged after other indirect registers have been written.
- R5: A pointer index of 6 or higher reads 0x00 through the window, and a window write to it changes no register. The reset slot also reads 0x00.
- R6: A window write of 0xA5 to the reset slot, followed by a window write of 0x5A to the slot, raises eng_soft_rst for exactly the one cycle after the 0x5A write.
- R7: When a write other than 0x5A follows 0xA5 at the reset slot, the key restarts from its first byte and no reset fires. This includes a second 0xA5.
- R8: On the edge that ends the eng_soft_rst pulse, every register returns to its R1 default.
- R9: Bit 6 of control is the engine enable, driven on eng_enable. While it is clear, status reads the idle code 0xF8. While it is set, status reads eng_status.
- R10: A host write presented during the eng_soft_rst cycle is lost, because the soft reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Write strobe for the addressed register |
| host_addr | input | 3 | Direct register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the addressed register (combinational) |
| eng_status | input | 8 | Status code reported by the serial engine |
| eng_enable | output | 1 | Engine enable from the control register |
| eng_soft_rst | output | 1 | One-cycle soft reset pulse |
| tx_data | output | 8 | Data register contents |
| cfg_own_addr | output | 8 | Own-address setting |
| cfg_scl_lo | output | 8 | Clock low-phase count |
| cfg_scl_hi | output | 8 | Clock high-phase count |
| cfg_timeout | output | 8 | Timeout setting |
| cfg_mode | output | 8 | Mode setting |

## Verification
The soft-reset pulse and an ordinary host write can fall in the same cycle. The host can present a new write, such as a data-register update, on the cycle right after completing the key. The bench provokes this by driving a data write while eng_soft_rst is high. It then judges the outcome on the following cycle: the data register must read the default 0x00, and every cfg output must be back at its default. The bench also runs the key after the clock counts have been changed, so that the reset visibly restores them.

// File: rtl/ixreg_pkg.sv
package ixreg_pkg;

    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int NREG  = 5;            // implemented indirect registers
    localparam int KEY_IX = NREG;        // reset slot follows the bank

    typedef enum logic [AW-1:0] {
        DA_STATUS = 3'd0,
        DA_DATA   = 3'd1,
        DA_PTR    = 3'd2,
        DA_WIN    = 3'd3,
        DA_CTRL   = 3'd4
    } dir_addr_e;

    localparam int IX_OWN   = 0;
    localparam int IX_SCLLO = 1;
    localparam int IX_SCLHI = 2;
    localparam int IX_TMO   = 3;
    localparam int IX_MODE  = 4;

    localparam logic [DW-1:0] KEY_FIRST  = 8'hA5;
    localparam logic [DW-1:0] KEY_SECOND = 8'h5A;
    localparam logic [DW-1:0] IDLE_CODE  = 8'hF8;
    localparam int            CTRL_EN    = 6;

    typedef enum logic {
        KS_WAIT_FIRST  = 1'b0,
        KS_WAIT_SECOND = 1'b1
    } key_state_e;

    typedef struct packed {
        logic [DW-1:0] own_addr;
        logic [DW-1:0] scl_lo;
        logic [DW-1:0] scl_hi;
        logic [DW-1:0] timeout;
        logic [DW-1:0] mode;
    } bank_cfg_t;

    function automatic logic [DW-1:0] bank_default(input int ix);
        case (ix)
            IX_OWN:   return 8'hE0;
            IX_SCLLO: return 8'h9D;
            IX_SCLHI: return 8'h86;
            IX_TMO:   return 8'hFF;
            default:  return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ixreg_key_seq.sv
module ixreg_key_seq
    import ixreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_we,
    input  logic [DW-1:0] slot_data,
    output logic          fire
);

    key_state_e state_q, state_d;
    logic       fire_d;

    always_comb begin
        state_d = state_q;
        fire_d  = 1'b0;
        if (slot_we) begin
            case (state_q)
                KS_WAIT_FIRST: begin
                    if (slot_data == KEY_FIRST) state_d = KS_WAIT_SECOND;
                end
                KS_WAIT_SECOND: begin
                    state_d = KS_WAIT_FIRST;
                    if (slot_data == KEY_SECOND) fire_d = 1'b1;
                end
                default: state_d = KS_WAIT_FIRST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || fire) begin
            state_q <= KS_WAIT_FIRST;
            fire    <= 1'b0;
        end else begin
            state_q <= state_d;
            fire    <= fire_d;
        end
    end

endmodule

// File: rtl/ixreg_bank.sv
module ixreg_bank
    import ixreg_pkg::*;
#(
    parameter int N_REG = NREG,
    parameter int IDX_W = DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             win_we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             key_we,
    output bank_cfg_t        cfg
);

    localparam logic [IDX_W-1:0] KEY_SLOT = IDX_W'(N_REG);

    logic [DW-1:0] regs_q [N_REG];

    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst || soft_rst)
                regs_q[g] <= bank_default(g);
            else if (win_we && idx == IDX_W'(g))
                regs_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (idx == IDX_W'(i)) rdata = regs_q[i];
        end
    end

    assign key_we = win_we && (idx == KEY_SLOT);

    assign cfg.own_addr = regs_q[IX_OWN];
    assign cfg.scl_lo   = regs_q[IX_SCLLO];
    assign cfg.scl_hi   = regs_q[IX_SCLHI];
    assign cfg.timeout  = regs_q[IX_TMO];
    assign cfg.mode     = regs_q[IX_MODE];

endmodule

// File: rtl/ixreg_direct.sv
module ixreg_direct
    import ixreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] eng_status,
    input  logic [DW-1:0] win_rdata,
    output logic [DW-1:0] host_rdata,
    output logic          win_we,
    output logic [DW-1:0] ptr_q,
    output logic [DW-1:0] data_q,
    output logic [DW-1:0] ctrl_q
);

    dir_addr_e addr;
    assign addr = dir_addr_e'(host_addr);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ptr_q  <= '0;
            data_q <= '0;
            ctrl_q <= '0;
        end else if (host_we) begin
            case (addr)
                DA_DATA: data_q <= host_wdata;
                DA_PTR:  ptr_q  <= host_wdata;
                DA_CTRL: ctrl_q <= host_wdata;
                default: ;
            endcase
        end
    end

    assign win_we = host_we && (addr == DA_WIN) && !soft_rst;

    always_comb begin
        case (addr)
            DA_STATUS: host_rdata = ctrl_q[CTRL_EN] ? eng_status : IDLE_CODE;
            DA_DATA:   host_rdata = data_q;
            DA_PTR:    host_rdata = ptr_q;
            DA_WIN:    host_rdata = win_rdata;
            DA_CTRL:   host_rdata = ctrl_q;
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ixreg_frontend.sv
module ixreg_frontend
    import ixreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          host_we,
    input  logic [2:0]    host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic [7:0]    eng_status,
    output logic          eng_enable,
    output logic          eng_soft_rst,
    output logic [7:0]    tx_data,
    output logic [7:0]    cfg_own_addr,
    output logic [7:0]    cfg_scl_lo,
    output logic [7:0]    cfg_scl_hi,
    output logic [7:0]    cfg_timeout,
    output logic [7:0]    cfg_mode
);

    logic          win_we;
    logic          key_we;
    logic [DW-1:0] win_rdata;
    logic [DW-1:0] ptr_q;
    logic [DW-1:0] ctrl_q;
    bank_cfg_t     cfg;

    ixreg_direct u_direct (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (eng_soft_rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .eng_status (eng_status),
        .win_rdata  (win_rdata),
        .host_rdata (host_rdata),
        .win_we     (win_we),
        .ptr_q      (ptr_q),
        .data_q     (tx_data),
        .ctrl_q     (ctrl_q)
    );

    ixreg_bank #(
        .N_REG (NREG),
        .IDX_W (DW)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (eng_soft_rst),
        .win_we   (win_we),
        .idx      (ptr_q),
        .wdata    (host_wdata),
        .rdata    (win_rdata),
        .key_we   (key_we),
        .cfg      (cfg)
    );

    ixreg_key_seq u_key (
        .clk       (clk),
        .rst       (rst),
        .slot_we   (key_we),
        .slot_data (host_wdata),
        .fire      (eng_soft_rst)
    );

    assign eng_enable   = ctrl_q[CTRL_EN];
    assign cfg_own_addr = cfg.own_addr;
    assign cfg_scl_lo   = cfg.scl_lo;
    assign cfg_scl_hi   = cfg.scl_hi;
    assign cfg_timeout  = cfg.timeout;
    assign cfg_mode     = cfg.mode;

endmodule

// File: rtl/ixreg_checker.sv
module ixreg_checker (
    input logic       clk,
    input logic       rst,
    input logic       host_we,
    input logic [2:0] host_addr,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic [7:0] ptr_q,
    input logic       eng_soft_rst,
    input logic       eng_enable,
    input logic [7:0] cfg_own_addr,
    input logic [7:0] cfg_scl_lo,
    input logic [7:0] cfg_scl_hi,
    input logic [7:0] cfg_timeout,
    input logic [7:0] cfg_mode
);

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        eng_soft_rst |=> !eng_soft_rst); // R6

    AST_PULSE_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
        eng_soft_rst |-> ($past(host_we) && $past(host_addr) == 3'd3 &&
                          $past(ptr_q) == 8'd5 && $past(host_wdata) == 8'h5A)); // R6

    AST_DEFAULTS_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
        $past(eng_soft_rst) |-> (cfg_own_addr == 8'hE0 && cfg_scl_lo == 8'h9D &&
                                 cfg_scl_hi == 8'h86 && cfg_timeout == 8'hFF &&
                                 cfg_mode == 8'h00 && !eng_enable && ptr_q == 8'h00)); // R8

    AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!eng_enable && host_addr == 3'd0) |-> host_rdata == 8'hF8); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (host_addr > 3'd4) |-> host_rdata == 8'h00); // R2

    AST_NO_CFG_WRITE_OUTSIDE_BANK: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 3'd3 && ptr_q >= 8'd5 && !eng_soft_rst)
        |=> ($stable(cfg_own_addr) && $stable(cfg_scl_lo) && $stable(cfg_scl_hi) &&
             $stable(cfg_timeout) && $stable(cfg_mode))); // R5

endmodule

bind ixreg_frontend ixreg_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_we      (host_we),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .ptr_q        (ptr_q),
    .eng_soft_rst (eng_soft_rst),
    .eng_enable   (eng_enable),
    .cfg_own_addr (cfg_own_addr),
    .cfg_scl_lo   (cfg_scl_lo),
    .cfg_scl_hi   (cfg_scl_hi),
    .cfg_timeout  (cfg_timeout),
    .cfg_mode     (cfg_mode)
);

// File: tb/ixreg_frontend_bench.sv
`timescale 1ns/1ps
module ixreg_frontend_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_we = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] eng_status = 8'h08;
    logic       eng_enable, eng_soft_rst;
    logic [7:0] tx_data, cfg_own_addr, cfg_scl_lo, cfg_scl_hi, cfg_timeout, cfg_mode;

    int n_cmp = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ixreg_frontend u_ixreg_frontend (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .eng_status(eng_status),
        .eng_enable(eng_enable), .eng_soft_rst(eng_soft_rst), .tx_data(tx_data),
        .cfg_own_addr(cfg_own_addr), .cfg_scl_lo(cfg_scl_lo), .cfg_scl_hi(cfg_scl_hi),
        .cfg_timeout(cfg_timeout), .cfg_mode(cfg_mode)
    );

    always @(posedge clk) if (!rst && eng_soft_rst) pulses <= pulses + 1;

    // {req, we, addr, data}: writes store data, reads expect data
    localparam int NV = 26;
    localparam logic [15:0] VECS [0:NV-1] = '{
        {4'd2, 1'b1, 3'd1, 8'h3C}, {4'd2, 1'b0, 3'd1, 8'h3C},   // R2 data
        {4'd2, 1'b1, 3'd0, 8'h55}, {4'd2, 1'b0, 3'd0, 8'hF8},   // R2 status write ignored
        {4'd9, 1'b1, 3'd4, 8'h40}, {4'd9, 1'b0, 3'd4, 8'h40},   // R9 enable
        {4'd9, 1'b0, 3'd0, 8'h08},
        {4'd9, 1'b1, 3'd4, 8'h00}, {4'd9, 1'b0, 3'd0, 8'hF8},
        {4'd2, 1'b0, 3'd5, 8'h00}, {4'd2, 1'b0, 3'd7, 8'h00},   // R2 unmapped
        {4'd3, 1'b1, 3'd2, 8'h01}, {4'd3, 1'b0, 3'd2, 8'h01},   // R3 pointer
        {4'd3, 1'b1, 3'd3, 8'h2A}, {4'd3, 1'b0, 3'd3, 8'h2A},
        {4'd3, 1'b1, 3'd2, 8'h03}, {4'd3, 1'b0, 3'd3, 8'hFF},
        {4'd4, 1'b1, 3'd2, 8'h00}, {4'd4, 1'b1, 3'd3, 8'hAA},   // R4 own address
        {4'd4, 1'b1, 3'd2, 8'h03}, {4'd4, 1'b1, 3'd3, 8'h00},
        {4'd4, 1'b1, 3'd2, 8'h00}, {4'd4, 1'b0, 3'd3, 8'hAA},
        {4'd5, 1'b1, 3'd2, 8'h09}, {4'd5, 1'b1, 3'd3, 8'h77},   // R5 unimplemented
        {4'd5, 1'b0, 3'd3, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic cfg_defaults(input string req);
        check(req, cfg_own_addr, 8'hE0);
        check(req, cfg_scl_lo, 8'h9D);
        check(req, cfg_scl_hi, 8'h86);
        check(req, cfg_timeout, 8'hFF);
        check(req, cfg_mode, 8'h00);
    endtask

    initial begin
        logic [7:0] v;
        int p0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd1, v); check("R1", v, 8'h00);
        rd(3'd2, v); check("R1", v, 8'h00);
        rd(3'd4, v); check("R1", v, 8'h00);
        cfg_defaults("R1");
        check("R1", {7'd0, eng_soft_rst}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][11]) wr(VECS[i][10:8], VECS[i][7:0]);
            else begin
                rd(VECS[i][10:8], v);
                check($sformatf("R%0d", VECS[i][15:12]), v, VECS[i][7:0]);
            end
        end
        // R3 cfg outputs track the bank, R5 nothing disturbed by index 9
        check("R3", cfg_scl_lo, 8'h2A);
        check("R5", cfg_own_addr, 8'hAA);
        check("R5", cfg_timeout, 8'h00);

        // R5 reset slot reads zero
        wr(3'd2, 8'h05); rd(3'd3, v); check("R5", v, 8'h00);

        // R7 broken keys
        p0 = pulses;
        wr(3'd3, 8'hA5); wr(3'd3, 8'h11); wr(3'd3, 8'h5A);
        wr(3'd3, 8'hA5); wr(3'd3, 8'hA5); wr(3'd3, 8'h5A);
        @(negedge clk);
        check("R7", 8'(pulses - p0), 8'h00);
        check("R7", cfg_scl_lo, 8'h2A);

        // R6 R8 R10 valid key, host write collides with the pulse
        wr(3'd4, 8'h40);
        wr(3'd3, 8'hA5);
        @(negedge clk);
        host_we = 1'b1; host_addr = 3'd3; host_wdata = 8'h5A;
        @(negedge clk);
        check("R6", {7'd0, eng_soft_rst}, 8'h01);
        host_addr = 3'd1; host_wdata = 8'h99;     // write during pulse
        @(negedge clk);
        host_we = 1'b0;
        check("R6", {7'd0, eng_soft_rst}, 8'h00);
        check("R10", tx_data, 8'h00);
        cfg_defaults("R8");
        check("R8", {7'd0, eng_enable}, 8'h00);
        rd(3'd2, v); check("R8", v, 8'h00);
        rd(3'd3, v); check("R8", v, 8'hE0);
        rd(3'd0, v); check("R9", v, 8'hF8);
        @(negedge clk);
        check("R6", 8'(pulses - p0), 8'h01);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule